// File: doc/BRIEF.md
# Prioritized Switch Allocator for a Bypass / Central-Buffer Router

This block decides, every cycle, which flits of a router move and where they go. A router of this kind has two paths. On the bypass path a flit goes straight from an input buffer to its output port. On the buffered path a flit is parked in a shared central buffer and leaves it later. The allocator resolves three classes of request at once: central buffer to output, input to output (bypass), and input into the central buffer. The classes have a fixed priority order, and requesters inside each class are served in round-robin order.

A head flit whose lookahead output is available takes the bypass. If that output is held or taken, the head flit asks for the central buffer instead. That request succeeds only if the buffer has room for a whole packet plus one spare flit. Whichever path the head flit wins, the rest of its packet, up to and including the tail, keeps that path. The shared buffer has one write port and one read port. Each port is therefore held by one packet from its head flit to its tail flit.

Grants are combinational and are valid in the same cycle as the requests. Packet ownership, the central-buffer port owners and the round-robin pointers live in registers.

Top module: `rcb_alloc`

## Requirements
- R1: When the central buffer is granted an output port in a cycle, no input receives a bypass grant for that port in the same cycle.
- R2: A head flit whose lookahead output is neither held by a packet nor taken by the central buffer in that cycle, and which wins that output's arbitration, receives a bypass grant. It does not receive a central-buffer write grant in that cycle.
- R3: A head flit at a free input that receives no bypass grant requests central-buffer entry. It is granted when the write port is free, it wins arbitration and the space rule holds.
- R4: After a non-tail flit of a packet is granted a path, every later valid flit at that input receives the same kind of grant (same output, or central-buffer write), up to and including the tail flit.
- R5: At most one central-buffer read grant and at most one central-buffer write grant are issued per cycle. Each port stays with one packet from its head flit to its tail flit, so a different packet's head waits.
- R6: A new packet is granted central-buffer entry only when `cb_free` ≥ PKT_LEN+1. Later flits of a packet already entering are granted whatever the value of `cb_free`.
- R7: Each output port and each central-buffer port arbitrates among its new requesters round-robin, starting after the last winner. The pointer moves only when a tail flit is granted, to the index after that flit's owner.
- R8: No output port receives more than one grant per cycle (bypass or buffer read), and no input receives more than one grant per cycle (bypass or buffer write).
- R9: An output held by an in-progress packet is unavailable to every other input and to the central buffer until the cycle after that packet's tail flit is granted.
- R10: After reset no port is held, all pointers are at index 0, and with no requests every grant output is zero.
- R11: Bypass grant bit `i*N+o` of `ib_out_gnt` means input `i` is granted output `o`. Bit `o` of `cb_rd_gnt` grants the central-buffer queue of output `o`, and bit `i` of `cb_wr_gnt` grants input `i` a buffer write. The lookahead output of input `i` is field `in_dest[i*PW +: PW]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | N | A flit is present at input i |
| in_head | input | N | Flit at input i is a head flit |
| in_tail | input | N | Flit at input i is a tail flit (head and tail together mean a single-flit packet) |
| in_dest | input | N*PW | Lookahead output port of each input's flit |
| cb_nonempty | input | N | The central-buffer queue for output o holds a flit |
| cb_tail | input | N | The front flit of the queue for output o is a tail flit |
| cb_free | input | FREE_W | Free flit slots in the central buffer |
| ib_out_gnt | output | N*N | Bypass grants, bit i*N+o |
| cb_rd_gnt | output | N | Central-buffer read grant, one-hot by output |
| cb_wr_gnt | output | N | Central-buffer write grant, one-hot by input |

## Verification
The assertions assume well-formed packet streams. An input that owns a path presents body and tail flits, never a new head, until its tail has been granted. A free input presents a head flit first. A queue in the central buffer starts with a head flit. The assertions also assume that `in_dest` stays constant within a packet. The directed tasks build each packet explicitly as a head, zero or more bodies and a tail, and every task ends on a tail grant or a single-flit packet, so no port is left held by a partial packet when the next scenario starts. The round-robin scenario counts back from earlier tasks to know which pointer values it starts from.

// File: rtl/rcb_alloc_pkg.sv
package rcb_alloc_pkg;

    // index following idx in a ring of n entries
    function automatic int wrap_inc(int idx, int n);
        return (idx + 1 >= n) ? 0 : idx + 1;
    endfunction

    // width needed to index n entries, at least one bit
    function automatic int idx_width(int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/rcb_rr_arb.sv
module rcb_rr_arb
    import rcb_alloc_pkg::*;
#(
    parameter int N = 5
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [N-1:0]                 req,
    input  logic                         adv,
    input  logic [idx_width(N)-1:0]      adv_idx,
    output logic [N-1:0]                 gnt
);
    localparam int IW = idx_width(N);

    typedef struct packed {
        logic [IW-1:0] ptr;
    } arb_st_t;

    arb_st_t st_d, st_q;

    always_comb begin
        logic found;
        st_d  = st_q;
        gnt   = '0;
        found = 1'b0;
        for (int k = 0; k < N; k++) begin
            int j;
            j = int'(st_q.ptr) + k;
            if (j >= N) j = j - N;
            if (!found && req[j]) begin
                gnt[j] = 1'b1;
                found  = 1'b1;
            end
        end
        if (adv) st_d.ptr = IW'(wrap_inc(int'(adv_idx), N));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R7
    ptr_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(st_q.ptr));

endmodule

// File: rtl/rcb_cb_port.sv
module rcb_cb_port
    import rcb_alloc_pkg::*;
#(
    parameter int N = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N-1:0]             new_req,
    input  logic [N-1:0]             own_req,
    input  logic [N-1:0]             tail,
    output logic [N-1:0]             gnt,
    output logic                     busy,
    output logic [idx_width(N)-1:0]  owner
);
    localparam int IW = idx_width(N);

    typedef struct packed {
        logic          lock;
        logic [IW-1:0] own;
    } port_st_t;

    port_st_t st_d, st_q;

    logic [N-1:0]  arb_req;
    logic [N-1:0]  arb_gnt;
    logic          arb_adv;
    logic [IW-1:0] arb_idx;

    always_comb begin
        arb_req = st_q.lock ? '0 : new_req;
    end

    rcb_rr_arb #(.N(N)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (arb_req),
        .adv     (arb_adv),
        .adv_idx (arb_idx),
        .gnt     (arb_gnt)
    );

    always_comb begin
        st_d    = st_q;
        gnt     = '0;
        arb_adv = 1'b0;
        arb_idx = '0;
        if (st_q.lock) begin
            if (own_req[st_q.own]) gnt[st_q.own] = 1'b1;
        end else begin
            gnt = arb_gnt;
        end
        for (int k = 0; k < N; k++) begin
            if (gnt[k]) begin
                arb_idx = IW'(k);
                if (tail[k]) begin
                    st_d.lock = 1'b0;
                    arb_adv   = 1'b1;
                end else begin
                    st_d.lock = 1'b1;
                    st_d.own  = IW'(k);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy  = st_q.lock;
    assign owner = st_q.own;

    // R5
    port_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.lock && ((gnt & tail) == '0)) |=> (st_q.lock && st_q.own == $past(st_q.own)));

endmodule

// File: rtl/rcb_alloc.sv
module rcb_alloc
    import rcb_alloc_pkg::*;
#(
    parameter int N       = 5,
    parameter int PKT_LEN = 4,
    parameter int FREE_W  = 6,
    parameter int PW      = idx_width(N)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         in_valid,
    input  logic [N-1:0]         in_head,
    input  logic [N-1:0]         in_tail,
    input  logic [N*PW-1:0]      in_dest,
    input  logic [N-1:0]         cb_nonempty,
    input  logic [N-1:0]         cb_tail,
    input  logic [FREE_W-1:0]    cb_free,
    output logic [N*N-1:0]       ib_out_gnt,
    output logic [N-1:0]         cb_rd_gnt,
    output logic [N-1:0]         cb_wr_gnt
);
    localparam int IW         = PW;
    localparam int SPACE_NEED = PKT_LEN + 1;

    typedef struct packed {
        logic [N-1:0]          lock;
        logic [N-1:0][IW-1:0]  src;
    } out_st_t;

    out_st_t st_d, st_q;

    logic [N-1:0][IW-1:0] dest;
    logic [N-1:0]         in_held;
    logic [N-1:0]         rd_new_req;
    logic                 rd_busy, wr_busy;
    logic [IW-1:0]        rd_own, wr_own;
    logic [N-1:0]         ib_req  [N];
    logic [N-1:0]         ib_arb_gnt [N];
    logic [N-1:0]         ib_adv;
    logic [N-1:0][IW-1:0] ib_adv_idx;
    logic [N-1:0][N-1:0]  col_g;
    logic [N-1:0]         row_any;
    logic [N-1:0]         wr_new_req;
    logic [N-1:0]         col_nontail;
    logic                 space_ok;

    // unpack lookahead ports, find inputs holding an output
    always_comb begin
        in_held = '0;
        for (int i = 0; i < N; i++) dest[i] = in_dest[i*PW +: PW];
        for (int o = 0; o < N; o++) begin
            if (st_q.lock[o]) in_held[st_q.src[o]] = 1'b1;
            rd_new_req[o] = cb_nonempty[o] && !st_q.lock[o];
        end
        space_ok = int'(cb_free) >= SPACE_NEED;
    end

    // class 1: central buffer to output
    rcb_cb_port #(.N(N)) u_rd_port (
        .clk     (clk),
        .rst_n   (rst_n),
        .new_req (rd_new_req),
        .own_req (cb_nonempty),
        .tail    (cb_tail),
        .gnt     (cb_rd_gnt),
        .busy    (rd_busy),
        .owner   (rd_own)
    );

    // class 2 requests: head flits to an output that is still available
    always_comb begin
        for (int o = 0; o < N; o++) begin
            logic avail;
            avail = !st_q.lock[o] && !cb_rd_gnt[o] && !(rd_busy && int'(rd_own) == o);
            for (int i = 0; i < N; i++) begin
                ib_req[o][i] = avail && in_valid[i] && in_head[i] && int'(dest[i]) == o
                               && !in_held[i] && !(wr_busy && int'(wr_own) == i);
            end
        end
    end

    for (genvar o = 0; o < N; o++) begin : g_out_arb
        rcb_rr_arb #(.N(N)) u_arb (
            .clk     (clk),
            .rst_n   (rst_n),
            .req     (ib_req[o]),
            .adv     (ib_adv[o]),
            .adv_idx (ib_adv_idx[o]),
            .gnt     (ib_arb_gnt[o])
        );
    end

    // class 2 grants and output ownership
    always_comb begin
        st_d        = st_q;
        col_g       = '0;
        ib_adv      = '0;
        ib_adv_idx  = '0;
        col_nontail = '0;
        for (int o = 0; o < N; o++) begin
            if (st_q.lock[o]) begin
                if (in_valid[st_q.src[o]]) col_g[o][st_q.src[o]] = 1'b1;
            end else begin
                col_g[o] = ib_arb_gnt[o];
            end
            for (int i = 0; i < N; i++) begin
                if (col_g[o][i]) begin
                    if (in_tail[i]) begin
                        st_d.lock[o]  = 1'b0;
                        ib_adv[o]     = 1'b1;
                        ib_adv_idx[o] = IW'(i);
                    end else begin
                        st_d.lock[o]   = 1'b1;
                        st_d.src[o]    = IW'(i);
                        col_nontail[o] = 1'b1;
                    end
                end
            end
        end
    end

    // class 3 requests: heads that did not get a bypass
    always_comb begin
        for (int i = 0; i < N; i++) begin
            row_any[i] = 1'b0;
            for (int o = 0; o < N; o++) row_any[i] = row_any[i] | col_g[o][i];
            wr_new_req[i] = in_valid[i] && in_head[i] && !in_held[i] && !row_any[i] && space_ok;
        end
    end

    rcb_cb_port #(.N(N)) u_wr_port (
        .clk     (clk),
        .rst_n   (rst_n),
        .new_req (wr_new_req),
        .own_req (in_valid),
        .tail    (in_tail),
        .gnt     (cb_wr_gnt),
        .busy    (wr_busy),
        .owner   (wr_own)
    );

    for (genvar i = 0; i < N; i++) begin : g_flat_i
        for (genvar o = 0; o < N; o++) begin : g_flat_o
            assign ib_out_gnt[i*N+o] = col_g[o][i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar o = 0; o < N; o++) begin : g_out_chk
        // R1
        cb_over_ib_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cb_rd_gnt[o] |-> (col_g[o] == '0));
        // R8
        out_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $countones({col_g[o], cb_rd_gnt[o]}) <= 1);
        // R9
        out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            col_nontail[o] |=> ((col_g[o] & ~$past(col_g[o])) == '0) && !cb_rd_gnt[o]);
    end

    for (genvar i = 0; i < N; i++) begin : g_in_chk
        // R8
        in_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $countones({row_any[i], cb_wr_gnt[i]}) <= 1);
    end

    // R5
    cb_ports_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cb_rd_gnt) && $onehot0(cb_wr_gnt));

    // R6
    wr_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cb_wr_gnt != '0) && !wr_busy) |-> (int'(cb_free) >= SPACE_NEED));

endmodule

// File: tb/rcb_alloc_tb.sv
module rcb_alloc_tb;
    localparam int N  = 5;
    localparam int PW = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    in_valid, in_head, in_tail, cb_nonempty, cb_tail;
    logic [N*PW-1:0] in_dest;
    logic [5:0]      cb_free;
    logic [N*N-1:0]  ib_out_gnt;
    logic [N-1:0]    cb_rd_gnt, cb_wr_gnt;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    rcb_alloc #(.N(N), .PKT_LEN(4), .FREE_W(6), .PW(PW)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_head(in_head),
        .in_tail(in_tail), .in_dest(in_dest), .cb_nonempty(cb_nonempty),
        .cb_tail(cb_tail), .cb_free(cb_free), .ib_out_gnt(ib_out_gnt),
        .cb_rd_gnt(cb_rd_gnt), .cb_wr_gnt(cb_wr_gnt)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] gv(int i, int o);
        return 32'(1) << (i*N + o);
    endfunction

    task automatic clr();
        in_valid = '0; in_head = '0; in_tail = '0; in_dest = '0;
        cb_nonempty = '0; cb_tail = '0; cb_free = 6'd10;
    endtask

    task automatic put(int i, bit h, bit t, int d);
        in_valid[i] = 1'b1; in_head[i] = h; in_tail[i] = t;
        in_dest[i*PW +: PW] = PW'(d);
    endtask

    task automatic cbq(int o);
        cb_nonempty[o] = 1'b1; cb_tail[o] = 1'b1;
    endtask

    task automatic t_reset();
        @(negedge clk); clr(); #1;
        chk("R10 bypass", 32'(ib_out_gnt), 0);
        chk("R10 read", 32'(cb_rd_gnt), 0);
        chk("R10 write", 32'(cb_wr_gnt), 0);
    endtask

    task automatic t_bypass();
        @(negedge clk); clr(); put(0, 1, 1, 2); #1;
        chk("R2 R11 bypass", 32'(ib_out_gnt), gv(0, 2));
        chk("R2 no write", 32'(cb_wr_gnt), 0);
    endtask

    task automatic t_cb_first();
        @(negedge clk); clr(); cbq(3); put(1, 1, 1, 3); #1;
        chk("R1 read", 32'(cb_rd_gnt), 32'b01000);
        chk("R1 no bypass", 32'(ib_out_gnt), 0);
        chk("R3 write", 32'(cb_wr_gnt), 32'b00010);
    endtask

    task automatic t_path_lock();
        @(negedge clk); clr(); put(0, 1, 0, 1); #1;
        chk("R4 head", 32'(ib_out_gnt), gv(0, 1));
        @(negedge clk); clr(); put(0, 0, 0, 1); put(2, 1, 1, 1); cbq(1); #1;
        chk("R4 body", 32'(ib_out_gnt), gv(0, 1));
        chk("R9 read blocked", 32'(cb_rd_gnt), 0);
        chk("R3 to buffer", 32'(cb_wr_gnt), 32'b00100);
        @(negedge clk); clr(); put(0, 0, 1, 1); cbq(1); #1;
        chk("R4 tail", 32'(ib_out_gnt), gv(0, 1));
        chk("R9 read blocked tail", 32'(cb_rd_gnt), 0);
        @(negedge clk); clr(); cbq(1); put(2, 1, 1, 1); #1;
        chk("R9 released", 32'(cb_rd_gnt), 32'b00010);
        chk("R9 no bypass", 32'(ib_out_gnt), 0);
    endtask

    task automatic t_space();
        @(negedge clk); clr(); cbq(0); put(3, 1, 1, 0); cb_free = 6'd4; #1;
        chk("R6 short space", 32'(cb_wr_gnt), 0);
        @(negedge clk); clr(); cbq(0); put(3, 1, 1, 0); cb_free = 6'd5; #1;
        chk("R6 enough space", 32'(cb_wr_gnt), 32'b01000);
    endtask

    task automatic t_wr_lock();
        @(negedge clk); clr(); cbq(4); put(0, 1, 0, 4); #1;
        chk("R5 read", 32'(cb_rd_gnt), 32'b10000);
        chk("R5 write head", 32'(cb_wr_gnt), 32'b00001);
        @(negedge clk); clr(); cbq(4); put(0, 0, 0, 4); put(1, 1, 1, 4); #1;
        chk("R5 write held", 32'(cb_wr_gnt), 32'b00001);
        chk("R5 other waits", 32'(ib_out_gnt), 0);
        @(negedge clk); clr(); put(0, 0, 1, 4); cb_free = 6'd0; #1;
        chk("R6 tail no space", 32'(cb_wr_gnt), 32'b00001);
        @(negedge clk); clr(); put(1, 1, 1, 4); #1;
        chk("R5 released", 32'(ib_out_gnt), gv(1, 4));
    endtask

    task automatic t_rr();
        // output 2 pointer stands at 1 after t_bypass
        @(negedge clk); clr(); cb_free = 0; put(1, 1, 0, 2); put(3, 1, 0, 2); #1;
        chk("R7 first", 32'(ib_out_gnt), gv(1, 2));
        @(negedge clk); clr(); cb_free = 0; put(1, 0, 0, 2); put(3, 1, 0, 2); #1;
        chk("R7 body", 32'(ib_out_gnt), gv(1, 2));
        @(negedge clk); clr(); cb_free = 0; put(1, 0, 1, 2); put(3, 1, 0, 2); #1;
        chk("R7 tail", 32'(ib_out_gnt), gv(1, 2));
        @(negedge clk); clr(); cb_free = 0; put(1, 1, 1, 2); put(3, 1, 1, 2); #1;
        chk("R7 rotate", 32'(ib_out_gnt), gv(3, 2));
        @(negedge clk); clr(); cb_free = 0; put(1, 1, 1, 2); put(3, 1, 1, 2); #1;
        chk("R7 wrap", 32'(ib_out_gnt), gv(1, 2));
    endtask

    task automatic t_multi();
        int bad;
        @(negedge clk); clr(); cbq(1); cbq(2); cbq(4);
        put(0, 1, 1, 1); put(2, 1, 1, 2); put(3, 1, 1, 3); #1;
        chk("R5 one read", 32'($countones(cb_rd_gnt)), 1);
        chk("R5 read requested", 32'(cb_rd_gnt & ~cb_nonempty), 0);
        chk("R5 one write", 32'($countones(cb_wr_gnt) <= 1), 1);
        chk("R2 free output", 32'(ib_out_gnt[3*N+3]), 1);
        bad = 0;
        for (int o = 0; o < N; o++) begin
            int c = cb_rd_gnt[o];
            for (int i = 0; i < N; i++) c += ib_out_gnt[i*N+o];
            if (c > 1) bad++;
        end
        for (int i = 0; i < N; i++) begin
            int c = cb_wr_gnt[i];
            for (int o = 0; o < N; o++) c += ib_out_gnt[i*N+o];
            if (c > 1) bad++;
        end
        chk("R8 single grants", 32'(bad), 0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                errors++;
                $display("FAIL watchdog actual=%0d expected=<20000", cycles);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        clr();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_bypass();
        t_cb_first();
        t_path_lock();
        t_space();
        t_wr_lock();
        t_rr();
        t_multi();
        @(negedge clk); clr();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule